// File: doc/BRIEF.md
# Bit-Serial Adder with Registered Sum Output

This block adds two unsigned operands of `WIDTH` bits by walking through them one bit per clock, least significant bit first. While `rst` is high, both operands are captured into right-shifting registers, the carry state is cleared and a down-counter is preset to `WIDTH`. Once `rst` falls, each clock edge presents the lowest remaining operand bits to a four-state carry machine. The state of that machine encodes both the running carry and the sum bit of the last position added.

Because the sum bit is taken from the state register rather than from logic on the inputs, it trails the operand bits by one clock. The result register therefore makes one more shift than the operand registers. This extra shift drops a leading pad bit and leaves bit 0 of the sum in place. After exactly `WIDTH + 1` clock edges without reset, `done` rises and the result stays frozen until the next reset. A new addition is started by pulsing `rst` with fresh operands on `op_a` and `op_b`.

Top module: `serial_sum_moore`

## Requirements
- R1: On the first clock edge that samples `rst` high, `sum` becomes 0 and `done` becomes 0.
- R2: The carry machine has four states, each giving a carry and a sum bit. The code is two bits: bit 1 is the carry and bit 0 is the sum bit. On each advancing edge, the next sum bit is a XOR b XOR carry and the next carry is the majority of a, b and carry.
- R3: When `done` is high, `sum` equals (`op_a` + `op_b`) mod 2^WIDTH, using the operand values present on the last reset edge.
- R4: `done` rises on the (WIDTH+1)-th rising edge after `rst` falls and not before.
- R5: While `rst` stays low, `done` stays high once set and `sum` does not change.
- R6: The carry out of bit WIDTH-1 is discarded. For example, all-ones plus one gives zero.
- R7: The result register shifts right on each edge before `done`, and the new bit enters at bit WIDTH-1. On edge 1 after reset the new bit is 0. On edge k (2 ≤ k ≤ WIDTH+1) it is bit k-2 of the true sum.
- R8: Changes on `op_a` and `op_b` while `rst` is low have no effect on `sum` or `done`.
- R9: Asserting `rst` in the middle of an addition abandons it and starts a fresh one with the operands then present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous, active high; loads the operands and restarts the addition |
| op_a | input | WIDTH | First operand, captured while `rst` is high |
| op_b | input | WIDTH | Second operand, captured while `rst` is high |
| sum | output | WIDTH | Result register, filled from the top one bit per clock |
| done | output | 1 | High once the full result is aligned in `sum` |

## Verification
The reference model predicts the contents of the result register after every edge, so partial sums are checked against the shift order as well as the final value. Operand pairs are chosen to separate different behaviours. A small sum with no carries catches bit-order mistakes. Alternating patterns (0xAA/0x55) never produce a carry. All-ones plus one and all-ones plus all-ones send a carry through every bit and out of the top, which tests the carry-to-state coding and the discarded overflow. Two separate runs test robustness: in one the operands are changed during a run, and in the other a reset arrives mid-run; these show whether inputs leak in after loading and whether a restart is clean.

// File: rtl/serial_sum_pkg.sv
package serial_sum_pkg;

   // bit 1 = carry, bit 0 = sum bit of the last position added
   typedef enum logic [1:0] {
      ST_G0 = 2'b00,
      ST_G1 = 2'b01,
      ST_H0 = 2'b10,
      ST_H1 = 2'b11
   } carry_st_t;

   function automatic carry_st_t step_state(input carry_st_t cur,
                                            input logic a, input logic b);
      logic cy;
      logic s;
      logic co;
      cy = cur[1];
      s  = a ^ b ^ cy;
      co = (a & b) | (a & cy) | (b & cy);
      return carry_st_t'({co, s});
   endfunction

endpackage

// File: rtl/ssa_shift_reg.sv
module ssa_shift_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         load,
   input  logic         en,
   input  logic         ser_in,
   input  logic [W-1:0] par_in,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_width
      $error("ssa_shift_reg: W must be at least 1");
   end

   logic [W-1:0] shifted;

   if (W == 1) begin : g_single
      assign shifted = ser_in;
   end else begin : g_multi
      assign shifted = {ser_in, q[W-1:1]};
   end

   always_ff @(posedge clk) begin
      if (load)
         q <= par_in;
      else if (en)
         q <= shifted;
   end

   // R7
   shift_top_chk: assert property (@(posedge clk) disable iff (load)
      (en && !load) |=> (q[W-1] == $past(ser_in)));

endmodule

// File: rtl/ssa_down_counter.sv
module ssa_down_counter #(
   parameter int START = 8,
   localparam int CW   = (START < 1) ? 1 : $clog2(START + 1)
) (
   input  logic          clk,
   input  logic          rst,
   output logic          zero,
   output logic [CW-1:0] value
);

   if (START < 1) begin : g_bad_start
      $error("ssa_down_counter: START must be at least 1");
   end

   localparam logic [CW-1:0] PRESET = CW'(START);

   always_ff @(posedge clk) begin
      if (rst)
         value <= PRESET;
      else if (value != '0)
         value <= value - 1'b1;
   end

   assign zero = (value == '0);

   // R4
   cnt_floor_chk: assert property (@(posedge clk) disable iff (rst)
      zero |=> zero);

   // R4
   cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(zero)) |-> (value == $past(value) - 1'b1));

endmodule

// File: rtl/ssa_carry_fsm.sv
module ssa_carry_fsm
   import serial_sum_pkg::*;
#(
   parameter bit ONE_HOT = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic adv,
   input  logic a_bit,
   input  logic b_bit,
   output logic sum_bit
);

   carry_st_t cur_st;
   carry_st_t nxt_st;

   assign nxt_st = step_state(cur_st, a_bit, b_bit);

   if (ONE_HOT) begin : g_onehot
      logic [3:0] oh;
      always_ff @(posedge clk) begin
         if (rst)
            oh <= 4'b0001;
         else if (adv)
            oh <= 4'b0001 << nxt_st;
      end
      always_comb begin
         if (oh[3])      cur_st = ST_H1;
         else if (oh[2]) cur_st = ST_H0;
         else if (oh[1]) cur_st = ST_G1;
         else            cur_st = ST_G0;
      end
      // R2
      onehot_code_chk: assert property (@(posedge clk) disable iff (rst)
         !$past(rst) |-> ($countones(oh) == 1));
   end else begin : g_binary
      always_ff @(posedge clk) begin
         if (rst)
            cur_st <= ST_G0;
         else if (adv)
            cur_st <= nxt_st;
      end
   end

   assign sum_bit = cur_st[0];

   // R2
   sum_rule_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(adv)) |->
         (cur_st[0] == ($past(a_bit) ^ $past(b_bit) ^ $past(cur_st[1]))));

   // R2
   carry_rule_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(adv)) |->
         (cur_st[1] == (($past(a_bit) & $past(b_bit)) |
                        ($past(a_bit) & $past(cur_st[1])) |
                        ($past(b_bit) & $past(cur_st[1])))));

   // R2
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(adv)) |-> $stable(cur_st));

endmodule

// File: rtl/serial_sum_moore.sv
module serial_sum_moore #(
   parameter int WIDTH       = 8,
   parameter bit ONE_HOT_FSM = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   output logic [WIDTH-1:0] sum,
   output logic             done
);

   localparam int CW = $clog2(WIDTH + 1);

   if (WIDTH < 1) begin : g_bad_width
      $error("serial_sum_moore: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] a_q;
   logic [WIDTH-1:0] b_q;
   logic             cnt_zero;
   logic [CW-1:0]    cnt_val;
   logic             run;
   logic             sum_bit;
   logic             sum_en;

   assign run    = !cnt_zero;
   assign sum_en = !done;

   ssa_shift_reg #(.W(WIDTH)) u_opa (
      .clk(clk), .load(rst), .en(run), .ser_in(1'b0),
      .par_in(op_a), .q(a_q)
   );

   ssa_shift_reg #(.W(WIDTH)) u_opb (
      .clk(clk), .load(rst), .en(run), .ser_in(1'b0),
      .par_in(op_b), .q(b_q)
   );

   ssa_down_counter #(.START(WIDTH)) u_cnt (
      .clk(clk), .rst(rst), .zero(cnt_zero), .value(cnt_val)
   );

   ssa_carry_fsm #(.ONE_HOT(ONE_HOT_FSM)) u_fsm (
      .clk(clk), .rst(rst), .adv(run),
      .a_bit(a_q[0]), .b_bit(b_q[0]), .sum_bit(sum_bit)
   );

   ssa_shift_reg #(.W(WIDTH)) u_res (
      .clk(clk), .load(rst), .en(sum_en), .ser_in(sum_bit),
      .par_in('0), .q(sum)
   );

   always_ff @(posedge clk) begin
      if (rst)
         done <= 1'b0;
      else if (cnt_zero)
         done <= 1'b1;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      $past(rst) |-> (sum == '0 && !done));

   // R4
   done_early_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt_val != '0) |-> !done);

   // R5
   done_hold_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> done);

   // R5
   sum_frozen_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> $stable(sum));

endmodule

// File: tb/serial_sum_moore_test.sv
module serial_sum_moore_test;

   localparam int W = 8;
   localparam longint MASK = (64'd1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic [W-1:0] sum;
   logic         done;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   serial_sum_moore #(.WIDTH(W)) uut (
      .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
      .sum(sum), .done(done)
   );

   always #2 clk = ~clk;

   task automatic check(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // reset with new operands, then run WIDTH+3 cycles against the model
   task automatic run_case(input longint a, input longint b, input bit scramble);
      longint total;
      longint model;
      longint bit_in;
      @(negedge clk);
      rst  = 1'b1;
      op_a = W'(a);
      op_b = W'(b);
      @(negedge clk);
      rst = 1'b0;
      check("R1 sum after reset", longint'(sum), 0);
      check("R1 done after reset", longint'(done), 0);
      total = (a + b);
      model = 0;
      for (int c = 1; c <= W + 3; c++) begin
         @(negedge clk);
         if (c <= W + 1) begin
            bit_in = (c == 1) ? 0 : ((total >> (c - 2)) & 1);
            model  = ((model >> 1) | (bit_in << (W - 1))) & MASK;
         end
         if (scramble) begin
            op_a = ~op_a;   // R8: must not reach the result
            op_b = op_b + 8'd37;
         end
         check("R7 sum shift", longint'(sum), model);
         check("R4 done timing", longint'(done), (c >= W + 1) ? 1 : 0);
      end
      check("R3 final sum", longint'(sum), total & MASK);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      run_case(5, 3, 0);                       // R3
      run_case(0, 0, 0);                       // R3
      run_case(8'hAA, 8'h55, 0);               // R2 no carries
      run_case(8'hFF, 8'h01, 0);               // R6 ripple, overflow dropped
      run_case(8'hFF, 8'hFF, 0);               // R2 carry held in H states, R6
      run_case(8'h80, 8'h80, 0);               // R6 top carry only
      run_case(8'h3C, 8'h71, 1);               // R8 operands toggled mid-run
      // R9: abandon a run partway, then restart
      @(negedge clk);
      rst = 1'b1; op_a = 8'h11; op_b = 8'h22;
      @(negedge clk);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      run_case(8'h9A, 8'h47, 0);
      // R5: done and sum hold across idle cycles
      repeat (20) @(negedge clk);
      check("R5 done held", longint'(done), 1);
      check("R5 sum held", longint'(sum), (64'h9A + 64'h47) & MASK);
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule